// File: doc/BRIEF.md
# Dual-Width One-Time-Programmable Memory Port

This block is a synthesizable behavioural model of a one-time-programmable memory as seen at its pins. A small parameterized array stands in for the cell matrix. An active-low chip select and an active-low output enable gate a 16-bit data bus. The bus carries a separate enable for each lane. A width select picks full-word reads or byte reads. In byte mode an extra least-significant address line chooses which half of the stored word appears on the low lane.

Voltage levels appear as two discrete flags. One marks the high-voltage condition on the identifier address pin. The other marks that the programming supply is present. With the supply present, a rising edge on the program strobe, sampled on the clock, ANDs the input data into the addressed word. Bits can therefore only be cleared. The identifier mode returns a fixed manufacturer or device code, each sealed to odd parity in its top bit.

Top module: `otp_dual_port`

## Requirements
- R1: With `chip_sel_n` high, `dq_oe` is all zero and `dq_o` is zero, whatever `out_en_n` is.
- R2: With `chip_sel_n` low and `out_en_n` high, `dq_oe` is all zero and `dq_o` is zero.
- R3: In word mode (`byte_mode`=0) with both enables low, `dq_oe` is 16'hFFFF and `dq_o` is the word at array index `addr[ARR_AW-1:0]`. `lsb_addr` has no effect.
- R4: In byte mode (`byte_mode`=1) with both enables low, `dq_oe` is 16'h00FF and `dq_o[15:8]` is zero. `lsb_addr`=1 places word bits 15..8 on `dq_o[7:0]`, and `lsb_addr`=0 places word bits 7..0 there.
- R5: After reset every array word reads as 16'hFFFF.
- R6: With `chip_sel_n` low, `out_en_n` high and `vpp_on` high, the first clock edge that samples `prog_strobe` high after it was low sets the addressed word to old & `din`. The result is readable from the next cycle, and a 1 in `din` never sets a cleared bit.
- R7: A strobe edge with `chip_sel_n` high, or with `vpp_on` low, leaves the array unchanged.
- R8: With `vpp_on` high and both enables low, reads (verify) give the same data and lane enables as R3 and R4.
- R9: With both enables low, `hv_id` high, and every address bit other than bit 0 and bit 9 low, the port returns the identifier instead of array data. Bit 0 low gives the manufacturer code 16'h00C2 and bit 0 high gives the device code 16'h0122. These codes are steered as in R3/R4.
- R10: When `hv_id` is high but any address bit other than bits 0 and 9 is set, the array word is read as normal.
- R11: Each identifier word has odd parity across its 16 bits, with bit 15 serving as the parity bit.
- R12: Holding `prog_strobe` high writes only once. Changes to `din` after the triggering edge have no effect until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the program strobe |
| rst_n | input | 1 | Active-low reset; blanks the array to all ones |
| chip_sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output gate |
| byte_mode | input | 1 | 1 = byte-wide reads, 0 = word-wide |
| addr | input | 17 | Word address |
| lsb_addr | input | 1 | Byte select inside the word in byte mode |
| hv_id | input | 1 | High-voltage flag on the identifier address pin |
| vpp_on | input | 1 | Programming supply present |
| prog_strobe | input | 1 | Program pulse; its rising edge writes |
| din | input | 16 | Data to program |
| dq_o | output | 16 | Output data lanes |
| dq_oe | output | 16 | Per-lane output enable |

## Verification
The bench programs a word twice with overlapping patterns, which shows whether bits can only be cleared. A design that overwrote instead of ANDing would bring back ones. It pulses the strobe while deselected and while the supply is absent. A design that ignored the select or the supply would then show a changed word on readback. The identifier tests put a set bit into the address field. An over-eager match would return a code where array data belongs, and a match that also checked bit 9 would fail on the 17'h200 address. Byte reads drive both values of `lsb_addr` and check that the upper lanes stay off, which exposes swapped halves or upper lanes left enabled.

// File: rtl/otp_port_pkg.sv
package otp_port_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;

  typedef enum logic [2:0] {
    OM_STANDBY,
    OM_INHIBIT,
    OM_DISABLE,
    OM_PROGRAM,
    OM_READ,
    OM_VERIFY,
    OM_IDENT
  } otp_mode_e;

  // Top bit becomes the parity bit so the whole word has odd parity.
  function automatic logic [WORD_W-1:0] seal_odd(input logic [WORD_W-1:0] v);
    return {~^v[WORD_W-2:0], v[WORD_W-2:0]};
  endfunction

  function automatic logic [LANE_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_port_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int ID_BIT = 9
) (
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              vpp_on,
  input  logic              hv_id,
  input  logic [ADDR_W-1:0] addr,
  output otp_mode_e         mode,
  output logic              id_hit,
  output logic              drive_en
);
  localparam logic [ADDR_W-1:0] ID_MASK =
    ~((ADDR_W'(1) << ID_BIT) | ADDR_W'(1));

  always_comb begin
    id_hit = hv_id && ((addr & ID_MASK) == '0);
    if (chip_sel_n)
      mode = vpp_on ? OM_INHIBIT : OM_STANDBY;
    else if (out_en_n)
      mode = vpp_on ? OM_PROGRAM : OM_DISABLE;
    else if (id_hit)
      mode = OM_IDENT;
    else
      mode = vpp_on ? OM_VERIFY : OM_READ;
    drive_en = (mode == OM_READ) || (mode == OM_VERIFY) || (mode == OM_IDENT);
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_mask,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[wr_idx] <= cells[wr_idx] & wr_mask;
    end
  end

  assign rd_word = cells[rd_idx];
endmodule

// File: rtl/otp_lane_steer.sv
module otp_lane_steer
  import otp_port_pkg::*;
(
  input  logic              drive_en,
  input  logic              byte_mode,
  input  logic              hi_sel,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] dq_o,
  output logic [WORD_W-1:0] dq_oe
);
  localparam int LANES = WORD_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_val;
    logic              lane_on;
    if (g == 0) begin : g_low
      assign lane_val = byte_mode ? pick_half(word, hi_sel)
                                  : word[LANE_W-1:0];
      assign lane_on  = drive_en;
    end else begin : g_high
      assign lane_val = word[g*LANE_W +: LANE_W];
      assign lane_on  = drive_en && !byte_mode;
    end
    assign dq_o [g*LANE_W +: LANE_W] = lane_on ? lane_val : '0;
    assign dq_oe[g*LANE_W +: LANE_W] = {LANE_W{lane_on}};
  end
endmodule

// File: rtl/otp_dual_port.sv
module otp_dual_port
  import otp_port_pkg::*;
#(
  parameter int              ADDR_W   = 17,
  parameter int              ARR_AW   = 6,
  parameter int              ID_BIT   = 9,
  parameter logic [15:0]     MFR_CODE = 16'h00C2,
  parameter logic [15:0]     DEV_CODE = 16'h0122
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lsb_addr,
  input  logic              hv_id,
  input  logic              vpp_on,
  input  logic              prog_strobe,
  input  logic [15:0]       din,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe
);
  otp_mode_e         mode;
  logic              id_hit;
  logic              drive_en;
  logic              strobe_q;
  logic              strobe_rise;
  logic              wr_fire;
  logic              ident_on;
  logic [ARR_AW-1:0] cell_idx;
  logic [WORD_W-1:0] cell_word;
  logic [WORD_W-1:0] id_word;
  logic [WORD_W-1:0] src_word;

  otp_mode_decode #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_dec (
    .chip_sel_n(chip_sel_n),
    .out_en_n  (out_en_n),
    .vpp_on    (vpp_on),
    .hv_id     (hv_id),
    .addr      (addr),
    .mode      (mode),
    .id_hit    (id_hit),
    .drive_en  (drive_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= prog_strobe;
  end

  assign strobe_rise = prog_strobe && !strobe_q;
  assign wr_fire     = (mode == OM_PROGRAM) && strobe_rise;
  assign ident_on    = (mode == OM_IDENT);
  assign cell_idx    = addr[ARR_AW-1:0];

  otp_cell_array #(.AW(ARR_AW), .DW(WORD_W)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_fire),
    .wr_idx (cell_idx),
    .wr_mask(din),
    .rd_idx (cell_idx),
    .rd_word(cell_word)
  );

  assign id_word  = seal_odd(addr[0] ? DEV_CODE : MFR_CODE);
  assign src_word = ident_on ? id_word : cell_word;

  otp_lane_steer u_steer (
    .drive_en (drive_en),
    .byte_mode(byte_mode),
    .hi_sel   (lsb_addr),
    .word     (src_word),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe)
  );
endmodule

// File: rtl/otp_dual_port_chk.sv
module otp_dual_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        chip_sel_n,
  input logic        out_en_n,
  input logic        byte_mode,
  input logic        vpp_on,
  input logic [15:0] dq_o,
  input logic [15:0] dq_oe,
  input logic        ident_on,
  input logic        wr_fire
);
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel_n |-> (dq_oe == 16'h0 && dq_o == 16'h0)); // R1
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && out_en_n) |-> (dq_oe == 16'h0)); // R2
  AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel_n && !out_en_n && !byte_mode) |-> (dq_oe == 16'hFFFF)); // R3
  AST_BYTE_UPPER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (dq_oe[15:8] == 8'h0 && dq_o[15:8] == 8'h0)); // R4
  AST_WRITE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (vpp_on && !chip_sel_n && out_en_n)); // R7
  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (ident_on && !byte_mode) |-> ($countones(dq_o) % 2 == 1)); // R11
endmodule

bind otp_dual_port otp_dual_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chip_sel_n(chip_sel_n),
  .out_en_n  (out_en_n),
  .byte_mode (byte_mode),
  .vpp_on    (vpp_on),
  .dq_o      (dq_o),
  .dq_oe     (dq_oe),
  .ident_on  (ident_on),
  .wr_fire   (wr_fire)
);

// File: tb/sim_otp_dual_port.sv
module sim_otp_dual_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel_n = 1'b1;
  logic        out_en_n = 1'b1;
  logic        byte_mode = 1'b0;
  logic [16:0] addr = '0;
  logic        lsb_addr = 1'b0;
  logic        hv_id = 1'b0;
  logic        vpp_on = 1'b0;
  logic        prog_strobe = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dq_o;
  logic [15:0] dq_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] ref_mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_dual_port u0 (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .byte_mode(byte_mode), .addr(addr), .lsb_addr(lsb_addr), .hv_id(hv_id),
    .vpp_on(vpp_on), .prog_strobe(prog_strobe), .din(din),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic cs, input logic oe, input logic bm,
                       input logic [16:0] a, input logic lsb, input logic hv,
                       input logic vpp);
    @(negedge clk);
    chip_sel_n = cs; out_en_n = oe; byte_mode = bm; addr = a;
    lsb_addr = lsb; hv_id = hv; vpp_on = vpp;
    #1;
  endtask

  // Strobe pulse with given select/supply; model updates only for a legal program cycle.
  task automatic pulse(input logic cs, input logic vpp, input logic [16:0] a,
                       input logic [15:0] d);
    apply(cs, 1'b1, 1'b0, a, 1'b0, 1'b0, vpp);
    din = d;
    @(negedge clk); prog_strobe = 1'b1;
    @(negedge clk); prog_strobe = 1'b0;
    if (!cs && vpp) ref_mem[a[5:0]] = ref_mem[a[5:0]] & d;
  endtask

  task automatic read_word(input string tag, input logic [16:0] a, input logic vpp);
    apply(1'b0, 1'b0, 1'b0, a, 1'b0, 1'b0, vpp);
    check({tag, " data"}, dq_o, ref_mem[a[5:0]]);
    check({tag, " lanes"}, dq_oe, 16'hFFFF);
  endtask

  task automatic t_reset_state;
    check("R1 reset standby lanes", dq_oe, 16'h0);
    check("R1 reset standby data", dq_o, 16'h0);
    read_word("R5 blank word 5", 17'd5, 1'b0);
    read_word("R5 blank word 63", 17'd63, 1'b0);
  endtask

  task automatic t_quiet_modes;
    apply(1'b1, 1'b0, 1'b0, 17'd5, 1'b0, 1'b0, 1'b0);
    check("R1 standby oe low", dq_oe, 16'h0);
    apply(1'b1, 1'b1, 1'b1, 17'd5, 1'b1, 1'b0, 1'b0);
    check("R1 standby oe high", dq_oe | dq_o, 16'h0);
    apply(1'b0, 1'b1, 1'b0, 17'd5, 1'b0, 1'b0, 1'b0);
    check("R2 disable lanes", dq_oe, 16'h0);
    check("R2 disable data", dq_o, 16'h0);
  endtask

  task automatic t_program_clear_only;
    pulse(1'b0, 1'b1, 17'd3, 16'h1234);
    read_word("R6 first program", 17'd3, 1'b0);
    pulse(1'b0, 1'b1, 17'd3, 16'hFFFF);
    read_word("R6 ones do not set", 17'd3, 1'b0);
    pulse(1'b0, 1'b1, 17'd3, 16'hF0F0);
    check("R6 and result", ref_mem[3], 16'h1030);
    read_word("R6 second program", 17'd3, 1'b0);
    apply(1'b0, 1'b0, 1'b0, 17'd3, 1'b1, 1'b0, 1'b0);
    check("R3 lsb_addr ignored in word mode", dq_o, 16'h1030);
  endtask

  task automatic t_byte_reads;
    apply(1'b0, 1'b0, 1'b1, 17'd3, 1'b1, 1'b0, 1'b0);
    check("R4 high half on low lane", dq_o, 16'h0010);
    check("R4 byte lanes", dq_oe, 16'h00FF);
    apply(1'b0, 1'b0, 1'b1, 17'd3, 1'b0, 1'b0, 1'b0);
    check("R4 low half on low lane", dq_o, 16'h0030);
  endtask

  task automatic t_inhibit;
    pulse(1'b1, 1'b1, 17'd3, 16'h0000);
    read_word("R7 deselected strobe", 17'd3, 1'b0);
    pulse(1'b0, 1'b0, 17'd3, 16'h0000);
    read_word("R7 no supply strobe", 17'd3, 1'b0);
  endtask

  task automatic t_verify;
    read_word("R8 verify word", 17'd3, 1'b1);
    apply(1'b0, 1'b0, 1'b1, 17'd3, 1'b1, 1'b0, 1'b1);
    check("R8 verify byte", dq_o, 16'h0010);
    check("R8 verify byte lanes", dq_oe, 16'h00FF);
  endtask

  task automatic t_ident;
    apply(1'b0, 1'b0, 1'b0, 17'd0, 1'b0, 1'b1, 1'b0);
    check("R9 manufacturer code", dq_o, 16'h00C2);
    check("R11 manufacturer parity", 16'(^dq_o), 16'h1);
    apply(1'b0, 1'b0, 1'b0, 17'd1, 1'b0, 1'b1, 1'b0);
    check("R9 device code", dq_o, 16'h0122);
    check("R11 device parity", 16'(^dq_o), 16'h1);
    apply(1'b0, 1'b0, 1'b0, 17'h200, 1'b0, 1'b1, 1'b0);
    check("R9 bit 9 does not matter", dq_o, 16'h00C2);
    apply(1'b0, 1'b0, 1'b1, 17'd0, 1'b1, 1'b1, 1'b0);
    check("R9 byte high of manufacturer", dq_o, 16'h0000);
    apply(1'b0, 1'b0, 1'b1, 17'd1, 1'b0, 1'b1, 1'b0);
    check("R9 byte low of device", dq_o, 16'h0022);
  endtask

  task automatic t_ident_miss;
    pulse(1'b0, 1'b1, 17'd2, 16'h5A5A);
    apply(1'b0, 1'b0, 1'b0, 17'd2, 1'b0, 1'b1, 1'b0);
    check("R10 bit1 set reads array", dq_o, 16'h5A5A);
    apply(1'b0, 1'b0, 1'b0, 17'h400, 1'b0, 1'b1, 1'b0);
    check("R10 bit10 set reads array", dq_o, ref_mem[0]);
  endtask

  task automatic t_single_write_per_edge;
    apply(1'b0, 1'b1, 1'b0, 17'd7, 1'b0, 1'b0, 1'b1);
    din = 16'hFF00;
    @(negedge clk); prog_strobe = 1'b1;
    @(negedge clk); din = 16'h0000;
    @(negedge clk);
    @(negedge clk); prog_strobe = 1'b0;
    ref_mem[7] = ref_mem[7] & 16'hFF00;
    read_word("R12 held strobe writes once", 17'd7, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    #1;
    t_reset_state_pre();
    rst_n = 1'b1;
    t_reset_state;
    t_quiet_modes;
    t_program_clear_only;
    t_byte_reads;
    t_inhibit;
    t_verify;
    t_ident;
    t_ident_miss;
    t_single_write_per_edge;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic t_reset_state_pre;
    check("R1 in reset lanes off", dq_oe, 16'h0);
  endtask
endmodule